// File: doc/BRIEF.md
# Parallel Stepper Command Fan-Out

This block takes command frames for 256 two-wire stepper drivers from an SPI target port and moves each frame out to 32 external 16-bit serial-in, parallel-out registers. Every external register has its own data line. One shift clock and one latch line are shared by all 32 registers. Each motor uses two control bits, a direction bit and a step bit, so one frame holds 512 bits. All 32 lanes move one bit on the same shift clock, so a whole frame is out after 16 shift clocks.

After the 16th rising shift edge, the block raises the shared latch. Every external register then moves its serial contents to its outputs on the same edge, so all 256 motors take their new command together. The block stores one complete received frame while it shifts out the one before it. A new frame can therefore stream in over SPI while the outputs are busy.

Top module: `stepper_fanout`

## Requirements
- R1: While reset is held, and until a frame has been received, `sr_clk`, `sr_latch`, every `sr_data` lane and `busy` are all low.
- R2: A frame is 512 bits. They are sampled on rising `spi_sclk` edges while `spi_cs_n` is low, and the first bit received becomes frame bit 511. Motor m owns frame bit 2m (step) and frame bit 2m+1 (direction). The word on lane L is frame bits 16L+15 down to 16L, so motor m appears on lane m/8 at word bit 2(m%8) (step) and bit 2(m%8)+1 (direction).
- R3: Each transfer makes exactly 16 rising edges on `sr_clk`. Each lane presents its word MSB first, and all lanes present the same bit position on the same edge.
- R4: `sr_data` changes only while `sr_clk` is low: at the start of a transfer, or together with a falling edge of `sr_clk`.
- R5: With H = `SCLK_HALF`, `sr_clk` rises H system cycles after `busy` rises. It then toggles every H cycles.
- R6: `sr_latch` rises 32·H cycles after `busy` rises, which is after the 16th rising shift edge. It stays high for exactly H cycles, with `sr_clk` low, and `busy` falls in the same cycle as `sr_latch`.
- R7: A frame that completes while a transfer is running is held. It does not disturb the running transfer and is shifted out as the next transfer.
- R8: When `spi_cs_n` rises before 512 bits have arrived, the partial frame is discarded and causes no transfer. Bits after the 512th bit within one select are ignored.
- R9: When a second frame completes while one is already held, the newer frame replaces the older one, and the older one is never shifted out.
- R10: When a transfer ends, every `sr_data` lane returns low together with the latch rise, and all outputs stay low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, data sampled on its rising edge |
| spi_cs_n | input | 1 | SPI select, active low, frames one command |
| spi_mosi | input | 1 | SPI serial data, MSB of the frame first |
| sr_clk | output | 1 | Shift clock shared by all external registers |
| sr_latch | output | 1 | Latch strobe shared by all external registers |
| sr_data | output | LANES | One serial data line per external register |
| busy | output | 1 | High from the start of shifting until the latch pulse ends |

## Verification
The SPI input passes through synchronizers, so its latency is not a requirement. Every timing figure is therefore measured from the rise of `busy`: the first shift edge H cycles later, the latch rise 32·H cycles later, and the latch fall together with the `busy` fall after another H cycles. The bench samples all outputs on the falling system clock and stamps each transition with a cycle counter, so it compares differences between stamps instead of waiting a fixed time. A bench model of the 32 external registers clocks in `sr_data` at each observed shift rise and keeps a record at each latch rise. Lane contents are checked against words built from the motor mapping once `busy` has fallen, and queued frames are checked by their order in that record.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_LATCH} shift_state_t;

  // position of word bit `pos` of lane `lane` inside the flat frame
  function automatic int slot_index(input int lane, input int pos, input int lane_bits);
    return lane * lane_bits + pos;
  endfunction

  // frame bit that carries the step control of motor m (direction is one above)
  function automatic int step_slot(input int m);
    return 2 * m;
  endfunction

endpackage

// File: rtl/fanout_spi_rx.sv
module fanout_spi_rx #(
  parameter int FRAME_BITS = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  done_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [2:0]    sclk_s;
  logic [1:0]    cs_s;
  logic [1:0]    mosi_s;
  logic [CW-1:0] cnt;
  logic          sclk_rise;
  logic          selected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign selected  = ~cs_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      frame_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!selected) begin
        cnt <= '0;                                   // partial frames are dropped
      end else if (sclk_rise && cnt != CW'(FRAME_BITS)) begin
        frame_o <= {frame_o[FRAME_BITS-2:0], mosi_s[1]};
        cnt     <= cnt + 1'b1;
        if (cnt == CW'(FRAME_BITS - 1)) done_o <= 1'b1;
      end
    end
  end

  // R2: one completion pulse per frame, never two in a row
  a_r2_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/fanout_hold.sv
module fanout_hold #(
  parameter int FRAME_BITS = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  put_i,
  input  logic                  take_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_o <= '0;
      valid_o <= 1'b0;
    end else begin
      if (put_i) begin
        frame_o <= frame_i;              // newest complete frame wins
        valid_o <= 1'b1;
      end else if (take_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  // R7: the shifter only takes a frame that is actually held
  a_r7_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> valid_o);

endmodule

// File: rtl/fanout_shifter.sv
module fanout_shifter
  import fanout_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int LANE_BITS = 16,
  parameter int SCLK_HALF = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES*LANE_BITS-1:0]  frame_i,
  input  logic                        start_i,
  output logic                        sr_clk,
  output logic                        sr_latch,
  output logic [LANES-1:0]            sr_data,
  output logic                        busy_o
);
  localparam int FRAME_BITS = LANES * LANE_BITS;
  localparam int PW  = $clog2(LANE_BITS);
  localparam int HCW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  shift_state_t          state;
  logic [FRAME_BITS-1:0] frame_q;
  logic [PW-1:0]         pos;
  logic [HCW-1:0]        cnt;
  logic                  half_done;

  function automatic logic [LANES-1:0] pick(input logic [FRAME_BITS-1:0] f,
                                            input logic [PW-1:0] p);
    logic [LANES-1:0] v;
    for (int l = 0; l < LANES; l++) v[l] = f[slot_index(l, int'(p), LANE_BITS)];
    return v;
  endfunction

  assign half_done = (cnt == HCW'(SCLK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      frame_q  <= '0;
      pos      <= '0;
      cnt      <= '0;
      sr_clk   <= 1'b0;
      sr_latch <= 1'b0;
      sr_data  <= '0;
      busy_o   <= 1'b0;
    end else begin
      case (state)
        SH_IDLE: begin
          if (start_i) begin
            frame_q <= frame_i;
            sr_data <= pick(frame_i, PW'(LANE_BITS - 1));
            pos     <= PW'(LANE_BITS - 1);
            cnt     <= '0;
            busy_o  <= 1'b1;
            state   <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (!half_done) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!sr_clk) begin
              sr_clk <= 1'b1;
            end else begin
              sr_clk <= 1'b0;
              if (pos == '0) begin
                sr_data  <= '0;
                sr_latch <= 1'b1;
                state    <= SH_LATCH;
              end else begin
                pos     <= pos - 1'b1;
                sr_data <= pick(frame_q, pos - 1'b1);
              end
            end
          end
        end
        SH_LATCH: begin
          if (!half_done) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt      <= '0;
            sr_latch <= 1'b0;
            busy_o   <= 1'b0;
            state    <= SH_IDLE;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  // ---- observation counters for the assertions ----
  logic          sclk_d;
  logic          sclk_rose;
  logic [PW:0]   rise_seen;
  int unsigned   latch_len;

  assign sclk_rose = sr_clk & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      rise_seen <= '0;
      latch_len <= 0;
    end else begin
      sclk_d    <= sr_clk;
      if (start_i)        rise_seen <= '0;
      else if (sclk_rose) rise_seen <= rise_seen + 1'b1;
      latch_len <= sr_latch ? latch_len + 1 : 0;
    end
  end

  // R3: exactly LANE_BITS shift edges precede the latch
  a_r3_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_latch) |-> rise_seen == (PW+1)'(LANE_BITS));
  // R4: lane data never moves while the shift clock is high
  a_r4_data_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_data != $past(sr_data)) |-> !sr_clk);
  // R6: latch pulse with clock low, inside busy, exactly SCLK_HALF long
  a_r6_latch_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    sr_latch |-> (!sr_clk && busy_o));
  a_r6_latch_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_latch) |-> latch_len == SCLK_HALF);
  // R7: a new transfer never starts over a running one
  a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  // R10: quiet outputs whenever idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sr_clk && !sr_latch && sr_data == '0));

endmodule

// File: rtl/stepper_fanout.sv
module stepper_fanout #(
  parameter int LANES     = 32,
  parameter int LANE_BITS = 16,
  parameter int SCLK_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             sr_clk,
  output logic             sr_latch,
  output logic [LANES-1:0] sr_data,
  output logic             busy
);
  localparam int FRAME_BITS = LANES * LANE_BITS;

  logic [FRAME_BITS-1:0] rx_frame;
  logic [FRAME_BITS-1:0] held_frame;
  logic                  rx_done;
  logic                  held_valid;
  logic                  start;

  assign start = held_valid & ~busy;

  fanout_spi_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .frame_o(rx_frame), .done_o(rx_done)
  );

  fanout_hold #(.FRAME_BITS(FRAME_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .frame_i(rx_frame), .put_i(rx_done), .take_i(start),
    .frame_o(held_frame), .valid_o(held_valid)
  );

  fanout_shifter #(.LANES(LANES), .LANE_BITS(LANE_BITS), .SCLK_HALF(SCLK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .frame_i(held_frame), .start_i(start),
    .sr_clk(sr_clk), .sr_latch(sr_latch), .sr_data(sr_data), .busy_o(busy)
  );

  // R1: outputs stay quiet until a held frame exists
  a_r1_no_spurious_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(held_valid));

endmodule

// File: tb/stepper_fanout_test.sv
module stepper_fanout_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int LB    = 16;
  localparam int FB    = LANES * LB;
  localparam int H     = 160;
  localparam int SPI_HALF = 2;
  localparam int NVEC  = 5;
  // {kind, seed}: 0 all idle, 1 all set, 2 alternating, 3 hashed
  localparam logic [33:0] VEC [0:NVEC-1] = '{
    {2'd0, 32'h0}, {2'd1, 32'h0}, {2'd2, 32'h0},
    {2'd3, 32'h1234_5678}, {2'd3, 32'hCAFE_0001}};

  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
  logic sr_clk, sr_latch, busy;
  logic [LANES-1:0] sr_data;

  stepper_fanout #(.LANES(LANES), .LANE_BITS(LB), .SCLK_HALF(H)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .sr_clk(sr_clk), .sr_latch(sr_latch),
    .sr_data(sr_data), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // motor command {dir, step}
  function automatic logic [1:0] cmd(input logic [1:0] kind, input logic [31:0] seed, input int m);
    logic [31:0] x;
    logic [8:0]  mm = 9'(m);
    case (kind)
      2'd0: return 2'b00;
      2'd1: return 2'b11;
      2'd2: return {mm[0], ~mm[0]};
      default: begin
        x = seed ^ (32'(m) * 32'h9E37_79B1);
        x = x ^ (x >> 13);
        x = x * 32'h85EB_CA6B;
        return x[17:16];
      end
    endcase
  endfunction

  function automatic logic [FB-1:0] build(input logic [1:0] kind, input logic [31:0] seed);
    logic [FB-1:0] f;
    logic [1:0] c;
    for (int m = 0; m < 256; m++) begin
      c = cmd(kind, seed, m);
      f[2*m]   = c[0];
      f[2*m+1] = c[1];
    end
    return f;
  endfunction

  // expected lane word straight from the motor mapping
  function automatic logic [15:0] lane_word(input logic [1:0] kind, input logic [31:0] seed, input int lane);
    logic [15:0] w;
    logic [1:0] c;
    for (int k = 0; k < 8; k++) begin
      c = cmd(kind, seed, lane * 8 + k);
      w[2*k]   = c[0];
      w[2*k+1] = c[1];
    end
    return w;
  endfunction

  // ---- output monitor with model of the external registers ----
  int cyc = 0, xfers = 0, rises = 0, rises_at_lat = 0, r4_viol = 0;
  int t_busy = 0, t_first = 0, t_lat_r = 0, t_lat_f = 0, t_busy_f = 0;
  logic p_busy = 0, p_clk = 0, p_lat = 0;
  logic [LANES-1:0] p_data = '0;
  logic [15:0] ext  [0:LANES-1];
  logic [15:0] hist [0:15][0:LANES-1];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && !p_busy) begin t_busy = cyc; rises = 0; end
      if (sr_clk && !p_clk) begin
        if (rises == 0) t_first = cyc;
        rises++;
        for (int l = 0; l < LANES; l++) ext[l] = {ext[l][14:0], sr_data[l]};
      end
      if (sr_data != p_data && sr_clk) r4_viol++;
      if (sr_latch && !p_lat) begin
        t_lat_r = cyc; rises_at_lat = rises;
        if (xfers < 16) for (int l = 0; l < LANES; l++) hist[xfers][l] = ext[l];
        xfers++;
      end
      if (!sr_latch && p_lat) t_lat_f = cyc;
      if (!busy && p_busy) t_busy_f = cyc;
    end
    p_busy = busy; p_clk = sr_clk; p_lat = sr_latch; p_data = sr_data;
  end

  task automatic spi_send(input logic [FB-1:0] f, input int nbits);
    spi_cs_n = 0;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < FB) ? f[FB-1-i] : 1'b1;
      repeat (SPI_HALF) @(negedge clk);
      spi_sclk = 1;
      repeat (SPI_HALF) @(negedge clk);
      spi_sclk = 0;
    end
    repeat (SPI_HALF) @(negedge clk);
    spi_cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_xfers(input int target);
    while (!(xfers >= target && !busy)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_hist(input int idx, input logic [1:0] kind, input logic [31:0] seed, input string req);
    for (int l = 0; l < LANES; l++)
      chk(hist[idx][l] == lane_word(kind, seed, l), req, hist[idx][l], lane_word(kind, seed, l));
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    int base;
    for (int l = 0; l < LANES; l++) ext[l] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({sr_clk, sr_latch, busy} == 3'b000 && sr_data == '0, "R1 in reset", {sr_clk, sr_latch, busy}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk({sr_clk, sr_latch, busy} == 3'b000 && sr_data == '0, "R1 after reset", {sr_clk, sr_latch, busy}, 0);

    // table of frame patterns
    for (int v = 0; v < NVEC; v++) begin
      base = xfers;
      spi_send(build(VEC[v][33:32], VEC[v][31:0]), FB);
      wait_xfers(base + 1);
      check_hist(base, VEC[v][33:32], VEC[v][31:0], "R2 lane word");
      chk(rises_at_lat == 16, "R3 shift edges", rises_at_lat, 16);
      chk(t_first - t_busy == H, "R5 first shift edge", t_first - t_busy, H);
      chk(t_lat_r - t_busy == 32 * H, "R6 latch rise", t_lat_r - t_busy, 32 * H);
      chk(t_lat_f - t_lat_r == H, "R6 latch width", t_lat_f - t_lat_r, H);
      chk(t_busy_f == t_lat_f, "R6 busy with latch", t_busy_f, t_lat_f);
      chk(sr_data == '0 && !sr_clk, "R10 idle low", sr_data, 0);
    end
    chk(r4_viol == 0, "R4 data while clock high", r4_viol, 0);

    // R7: frame arriving during a transfer is held
    base = xfers;
    spi_send(build(2'd3, 32'h0000_00A1), FB);
    spi_send(build(2'd3, 32'h0000_00B2), FB);
    chk(busy == 1'b1 && xfers == base, "R7 second frame arrived while busy", xfers, base);
    wait_xfers(base + 2);
    check_hist(base,     2'd3, 32'h0000_00A1, "R7 first transfer intact");
    check_hist(base + 1, 2'd3, 32'h0000_00B2, "R7 held frame follows");

    // R9: newer waiting frame replaces older waiting frame
    base = xfers;
    spi_send(build(2'd3, 32'h0000_0C01), FB);
    spi_send(build(2'd3, 32'h0000_0C02), FB);
    spi_send(build(2'd3, 32'h0000_0C03), FB);
    chk(xfers == base, "R9 both queued frames arrived during first", xfers, base);
    wait_xfers(base + 2);
    repeat (6000) @(negedge clk);
    chk(xfers == base + 2, "R9 replaced frame never shifted", xfers, base + 2);
    check_hist(base + 1, 2'd3, 32'h0000_0C03, "R9 newest frame shifted");

    // R8: partial frame dropped, surplus bits ignored
    base = xfers;
    spi_send(build(2'd3, 32'h0000_0D00), 300);
    repeat (200) @(negedge clk);
    chk(xfers == base && !busy, "R8 partial frame dropped", xfers, base);
    spi_send(build(2'd3, 32'h0000_0E00), FB + 8);
    wait_xfers(base + 1);
    check_hist(base, 2'd3, 32'h0000_0E00, "R8 surplus bits ignored");
    repeat (400) @(negedge clk);
    chk(xfers == base + 1, "R8 single transfer", xfers, base + 1);
    chk(r4_viol == 0, "R4 data while clock high", r4_viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule